// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block is the digital control shell around an 8-bit converter. Software uses three registers on a small bus port. The first is a control/status register with a channel number, an interrupt enable and a done flag. The second is a clock register that picks the converter clock source and a power-of-two divider. The third is a read-only result register. A write to the control/status register starts one conversion of the chosen channel. The conversion runs in the converter clock domain and lasts a fixed number of converter clock ticks. The converter clock is either the bus clock or a free-running external clock that has no phase relation to the bus.

The start request crosses into the converter domain as a toggle through a two-flop synchronizer. Completion comes back the same way. The result stays frozen in the converter domain until the bus side has taken the toggle and copied the value. The analog front end is outside this block. The bench supplies a 9-bit digitized sample. Bit 8 of that sample means the input lies above the high reference. Software can poll the done flag, or it can enable an interrupt that follows the flag.

Register map (regAddr): 0 is control/status: bit 7 done flag (read-only), bit 6 interrupt enable, bits 4:0 channel. 1 is clock setup: bit 4 source (1 = bus clock, 0 = external clock), bits 2:0 divider code. 2 is the result (read-only). Every other address reads as zero.

Top module: `convSeq`

## Requirements
- R1: After reset the control/status register reads 0x1F (channel 31, enable and flag clear), the clock register reads 0x00, the result reads 0x00 and irq is low.
- R2: One conversion spans exactly CONV_CYCLES (16) converter clock ticks. It begins on the first tick after the synchronized start request. With the bus clock at divide-by-1, the done flag is first seen 21 bus cycles after the write cycle.
- R3: A conversion converts the channel in bits 4:0 of the write that started it, and convChan shows that channel.
- R4: For a sample of 0x0FF or less the result equals the sample. For any sample with bit 8 set the result is 0xFF, so 0x000 gives 0x00.
- R5: The done flag (status bit 7) is set when a result is transferred. irq is high exactly when the flag and bit 6 are both set.
- R6: Any write to the control/status register clears the done flag and drops irq.
- R7: A read strobe on the result address clears the done flag.
- R8: Writing channel 31 (0x1F) starts no conversion. The flag stays clear and the result is unchanged.
- R9: Divider codes 0,1,2,3,4 divide the source by 1,2,4,8,16. Codes 5 to 7 divide by 16.
- R10: Clock register bit 4 selects the bus clock (1) or the external clock (0) as the divider source.
- R11: The result register changes only when a completed conversion is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| oscClk | input | 1 | External clock, asynchronous to busClk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (clears the flag on the result address) |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr |
| sampleIn | input | 9 | Digitized sample of the selected channel; bit 8 means above full scale |
| convChan | output | 5 | Channel latched at the start of the current conversion |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its defaults: 16 ticks per conversion and a divider cap of 2^4. With the bus clock at divide-by-1 the whole path is cycle-deterministic, so the 16-tick length and both synchronizer depths are checked against one exact latency. Divide-by-4 and the clamped code 7 are checked against latency windows that cannot overlap the windows of the neighbouring ratios. The external clock (14 ns) runs the asynchronous handshake. Its window excludes the result that would come from using the bus clock by mistake.

// File: rtl/convSeqPkg.sv
package convSeqPkg;
  localparam int CHAN_W     = 5;
  localparam int DATA_W     = 8;
  localparam int SAMPLE_W   = DATA_W + 1;
  localparam int DIV_CODE_W = 3;
  localparam logic [CHAN_W-1:0] CHAN_OFF = '1;

  // strobes from the bus-side control toward the converter datapath
  typedef struct packed {
    logic              startTgl;
    logic [CHAN_W-1:0] chan;
  } convCmd_t;

  typedef struct packed {
    logic                  srcBus;
    logic [DIV_CODE_W-1:0] divCode;
  } clkCfg_t;
endpackage

// File: rtl/convClkGen.sv
module convClkGen
  import convSeqPkg::*;
#(
  parameter int DIV_LOG_MAX = 4
) (
  input  logic    busClk,
  input  logic    oscClk,
  input  logic    rst_n,
  input  clkCfg_t cfg,
  output logic    convClk,
  output logic    convTick
);
  localparam int CNT_W = DIV_LOG_MAX + 1;
  localparam logic [DIV_CODE_W-1:0] DIV_CAP = DIV_CODE_W'(DIV_LOG_MAX);

  logic [DIV_CODE_W-1:0] shiftAmt;
  logic [CNT_W-1:0]      divLimit;
  logic [CNT_W-1:0]      divCnt;

  assign convClk = cfg.srcBus ? busClk : oscClk;

  always_comb begin
    shiftAmt = (cfg.divCode > DIV_CAP) ? DIV_CAP : cfg.divCode;
    divLimit = (CNT_W'(1) << shiftAmt) - CNT_W'(1);
  end

  assign convTick = (divCnt >= divLimit);

  always_ff @(posedge convClk or negedge rst_n) begin
    if (!rst_n)        divCnt <= '0;
    else if (convTick) divCnt <= '0;
    else               divCnt <= divCnt + CNT_W'(1);
  end
endmodule

// File: rtl/convDatapath.sv
module convDatapath
  import convSeqPkg::*;
#(
  parameter int CONV_CYCLES = 16
) (
  input  logic                convClk,
  input  logic                rst_n,
  input  logic                convTick,
  input  convCmd_t            cmd,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                doneTgl,
  output logic [DATA_W-1:0]   result,
  output logic [CHAN_W-1:0]   convChan
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_CYCLES - 1);

  logic reqS1, reqS2, reqSeen, reqEdge;
  logic pending, busy;
  logic [CNT_W-1:0]  tickCnt;
  logic [DATA_W-1:0] satVal;

  assign reqEdge = reqS2 ^ reqSeen;
  assign satVal  = sampleIn[DATA_W] ? '1 : sampleIn[DATA_W-1:0];

  always_ff @(posedge convClk or negedge rst_n) begin
    if (!rst_n) begin
      reqS1    <= 1'b0;
      reqS2    <= 1'b0;
      reqSeen  <= 1'b0;
      pending  <= 1'b0;
      busy     <= 1'b0;
      tickCnt  <= '0;
      doneTgl  <= 1'b0;
      result   <= '0;
      convChan <= CHAN_OFF;
    end else begin
      reqS1   <= cmd.startTgl;
      reqS2   <= reqS1;
      reqSeen <= reqS2;
      if (reqEdge) pending <= 1'b1;
      if (convTick) begin
        if (pending || reqEdge) begin
          // first tick of a conversion counts as tick one
          pending  <= 1'b0;
          busy     <= 1'b1;
          tickCnt  <= CNT_W'(1);
          convChan <= cmd.chan;
        end else if (busy) begin
          if (tickCnt == LAST_CNT) begin
            busy    <= 1'b0;
            result  <= satVal;
            doneTgl <= ~doneTgl;
          end else begin
            tickCnt <= tickCnt + CNT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/convCtrl.sv
module convCtrl
  import convSeqPkg::*;
(
  input  logic              busClk,
  input  logic              rst_n,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq,
  output convCmd_t          cmd,
  output clkCfg_t           clkCfg,
  input  logic              doneTgl,
  input  logic [DATA_W-1:0] result,
  output logic              doneFlag,
  output logic              doneEdge,
  output logic [DATA_W-1:0] dataReg
);
  localparam logic [1:0] ADDR_CSR  = 2'd0;
  localparam logic [1:0] ADDR_CLK  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  logic irqEn, doneS1, doneS2, doneSeen;
  logic csrWr, clkWr, dataRd;

  assign csrWr    = regWe && (regAddr == ADDR_CSR);
  assign clkWr    = regWe && (regAddr == ADDR_CLK);
  assign dataRd   = regRe && (regAddr == ADDR_DATA);
  assign doneEdge = doneS2 ^ doneSeen;
  assign irq      = doneFlag & irqEn;

  always_ff @(posedge busClk or negedge rst_n) begin
    if (!rst_n) begin
      irqEn        <= 1'b0;
      cmd.chan     <= CHAN_OFF;
      cmd.startTgl <= 1'b0;
      clkCfg       <= '0;
      doneS1       <= 1'b0;
      doneS2       <= 1'b0;
      doneSeen     <= 1'b0;
      doneFlag     <= 1'b0;
      dataReg      <= '0;
    end else begin
      doneS1   <= doneTgl;
      doneS2   <= doneS1;
      doneSeen <= doneS2;
      if (csrWr) begin
        irqEn    <= regWdata[6];
        cmd.chan <= regWdata[CHAN_W-1:0];
        if (regWdata[CHAN_W-1:0] != CHAN_OFF) cmd.startTgl <= ~cmd.startTgl;
      end
      if (clkWr) clkCfg <= {regWdata[4], regWdata[DIV_CODE_W-1:0]};
      if (doneEdge) begin
        dataReg  <= result;
        doneFlag <= 1'b1;
      end else if (csrWr || dataRd) begin
        doneFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CSR:  regRdata = {doneFlag, irqEn, 1'b0, cmd.chan};
      ADDR_CLK:  regRdata = {3'b000, clkCfg.srcBus, 1'b0, clkCfg.divCode};
      ADDR_DATA: regRdata = dataReg;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/convSeq.sv
module convSeq
  import convSeqPkg::*;
#(
  parameter int CONV_CYCLES = 16,
  parameter int DIV_LOG_MAX = 4
) (
  input  logic                busClk,
  input  logic                oscClk,
  input  logic                rst_n,
  input  logic                regWe,
  input  logic                regRe,
  input  logic [1:0]          regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [CHAN_W-1:0]   convChan,
  output logic                irq
);
  convCmd_t          cmd;
  clkCfg_t           clkCfg;
  logic              convClk, convTick, doneTgl, doneFlag, doneEdge;
  logic [DATA_W-1:0] result, dataReg;
  logic              startTgl;

  assign startTgl = cmd.startTgl;

  convCtrl u_ctrl (
    .busClk, .rst_n, .regWe, .regRe, .regAddr, .regWdata, .regRdata, .irq,
    .cmd, .clkCfg, .doneTgl, .result, .doneFlag, .doneEdge, .dataReg
  );

  convClkGen #(.DIV_LOG_MAX(DIV_LOG_MAX)) u_clk (
    .busClk, .oscClk, .rst_n, .cfg(clkCfg), .convClk, .convTick
  );

  convDatapath #(.CONV_CYCLES(CONV_CYCLES)) u_dp (
    .convClk, .rst_n, .convTick, .cmd, .sampleIn, .doneTgl, .result, .convChan
  );
endmodule

// File: rtl/convSeqChecker.sv
module convSeqChecker (
  input logic       busClk,
  input logic       rst_n,
  input logic       regWe,
  input logic       regRe,
  input logic [1:0] regAddr,
  input logic [7:0] regWdata,
  input logic       irq,
  input logic       doneFlag,
  input logic       doneEdge,
  input logic       startTgl,
  input logic [7:0] dataReg
);
  assert_irq_needs_flag_R5: assert property (@(posedge busClk) disable iff (!rst_n)
    irq |-> doneFlag);

  assert_flag_on_done_R5: assert property (@(posedge busClk) disable iff (!rst_n)
    doneEdge |=> doneFlag);

  assert_csr_write_clears_R6: assert property (@(posedge busClk) disable iff (!rst_n)
    (regWe && regAddr == 2'd0 && !doneEdge) |=> (!doneFlag && !irq));

  assert_data_read_clears_R7: assert property (@(posedge busClk) disable iff (!rst_n)
    (regRe && regAddr == 2'd2 && !doneEdge) |=> !doneFlag);

  assert_off_channel_no_start_R8: assert property (@(posedge busClk) disable iff (!rst_n)
    (regWe && regAddr == 2'd0 && regWdata[4:0] == 5'h1F) |=> $stable(startTgl));

  assert_result_hold_R11: assert property (@(posedge busClk) disable iff (!rst_n)
    !doneEdge |=> $stable(dataReg));
endmodule

bind convSeq convSeqChecker u_convSeqChecker (
  .busClk(busClk), .rst_n(rst_n), .regWe(regWe), .regRe(regRe),
  .regAddr(regAddr), .regWdata(regWdata), .irq(irq), .doneFlag(doneFlag),
  .doneEdge(doneEdge), .startTgl(startTgl), .dataReg(dataReg)
);

// File: tb/convSeq_bench.sv
module convSeq_bench;
  logic       busClk = 1'b0, oscClk = 1'b0, rst_n = 1'b0;
  logic       regWe = 1'b0, regRe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [8:0] sampleIn = 9'h000;
  logic [4:0] convChan;
  logic       irq;
  int checks = 0, errors = 0;

  always #5 busClk = ~busClk;
  always #7 oscClk = ~oscClk;

  convSeq u_convSeq (.*);

  // {irqEn, sample[8:0], channel[4:0], expected[7:0]}
  localparam logic [22:0] VEC [6] = '{
    {1'b0, 9'h000, 5'd0,  8'h00},
    {1'b1, 9'h0FF, 5'd3,  8'hFF},
    {1'b0, 9'h080, 5'd17, 8'h80},
    {1'b1, 9'h1A0, 5'd30, 8'hFF},
    {1'b0, 9'h100, 5'd8,  8'hFF},
    {1'b1, 9'h037, 5'd21, 8'h37}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge busClk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge busClk);
    regWe = 1'b0; regAddr = 2'd0;
  endtask

  task automatic rdClear();
    @(negedge busClk);
    regRe = 1'b1; regAddr = 2'd2;
    @(negedge busClk);
    regRe = 1'b0; regAddr = 2'd0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdata; regAddr = 2'd0; #1;
  endtask

  // counts bus cycles after the write until the flag shows
  task automatic waitDone(input int lim, output int n);
    n = 0;
    regAddr = 2'd0;
    do begin
      @(negedge busClk);
      n++;
    end while (!regRdata[7] && n < lim);
  endtask

  initial begin
    repeat (150000) @(posedge busClk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] d, held;
    repeat (3) @(negedge busClk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, d); chk(d == 8'h1F, "R1 csr", d, 8'h1F);
    peek(2'd1, d); chk(d == 8'h00, "R1 clk", d, 8'h00);
    peek(2'd2, d); chk(d == 8'h00, "R1 data", d, 8'h00);
    chk(irq == 1'b0, "R1 irq", irq, 0);

    // bus clock, divide by 1: exact latency
    wr(2'd1, 8'h10);
    peek(2'd1, d); chk(d == 8'h10, "R10 clk readback", d, 8'h10);
    for (int i = 0; i < 6; i++) begin
      logic [22:0] v = VEC[i];
      sampleIn = v[21:13];
      wr(2'd0, {1'b0, v[22], 1'b0, v[12:8]});
      waitDone(100, n);
      chk(n == 21, "R2 latency", n, 21);
      chk(convChan == v[12:8], "R3 channel", convChan, v[12:8]);
      peek(2'd2, d); chk(d == v[7:0], "R4 result", d, v[7:0]);
      chk(irq == v[22], "R5 irq", irq, v[22]);
      rdClear();
      peek(2'd0, d); chk(d[7] == 1'b0, "R7 flag after read", d[7], 0);
    end

    // R6 write clears flag and irq; R8 channel 31 starts nothing; R11 hold
    sampleIn = 9'h05A;
    wr(2'd0, 8'h42);
    waitDone(100, n);
    chk(irq == 1'b1, "R5 irq set", irq, 1);
    peek(2'd2, held);
    sampleIn = 9'h0C3;
    wr(2'd0, 8'h5F);
    peek(2'd0, d); chk(d[7] == 1'b0, "R6 flag cleared", d[7], 0);
    chk(irq == 1'b0, "R6 irq cleared", irq, 0);
    repeat (300) @(negedge busClk);
    peek(2'd0, d); chk(d[7] == 1'b0, "R8 no completion", d[7], 0);
    peek(2'd2, d); chk(d == held, "R11 result held", d, held);
    chk(held == 8'h5A, "R4 result", held, 8'h5A);

    // R9 divide by 4
    wr(2'd1, 8'h12);
    sampleIn = 9'h011;
    wr(2'd0, 8'h02);
    waitDone(400, n);
    chk(n >= 60 && n <= 73, "R9 div4 latency", n, 64);
    peek(2'd2, d); chk(d == 8'h11, "R9 div4 result", d, 8'h11);

    // R9 code 7 clamps to divide by 16
    wr(2'd1, 8'h17);
    sampleIn = 9'h0AA;
    wr(2'd0, 8'h04);
    waitDone(600, n);
    chk(n >= 240 && n <= 265, "R9 code7 latency", n, 256);
    peek(2'd2, d); chk(d == 8'hAA, "R9 code7 result", d, 8'hAA);

    // R10 external clock, divide by 2
    wr(2'd1, 8'h01);
    sampleIn = 9'h0E1;
    wr(2'd0, 8'h0B);
    waitDone(400, n);
    chk(n >= 42 && n <= 65, "R10 osc latency", n, 50);
    peek(2'd2, d); chk(d == 8'hE1, "R10 osc result", d, 8'hE1);
    chk(convChan == 5'd11, "R3 osc channel", convChan, 11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule